// File: doc/BRIEF.md
# Signed Min/Max/Absolute-Value Unit with Status Flags

This block is a two's-complement arithmetic slice that picks the larger or the smaller of two signed operands, or forms the magnitude of one operand. The result path has no registers, so the selected value is visible in the same cycle the operands and the operation code are presented. A small status word sits beside it and is loaded on the clock edge that ends every accepted operation. The status word holds zero, negative, carry and overflow bits, plus a sticky overflow bit that collects overflows until it is cleared.

Flags come from the produced result, not from an internal subtraction. For this reason, comparing operands whose difference would wrap never reports an overflow. The only operation that can overflow is the magnitude of the most negative number. That case saturates to the most positive number and records the event in both overflow bits. A pipeline stage drives the operands, the code and a valid strobe, and reads back the result and the flags. A separate clear input empties the sticky bit.

Top module: `sminmax_abs`

## Requirements
- R1: With operation code 2'b00 the result is whichever operand is larger as a signed number (for example 0x7FFFFFFF against 0xFFFFFFFF or 0x800FFFFF), and equal operands return that common value.
- R2: With operation code 2'b01 the result is whichever operand is smaller as a signed number (for example 0x80000001 against 0x00000000 or 0x0FF00000), and equal operands return that common value.
- R3: With operation code 2'b10 only operand A is used. A non-negative value passes unchanged, a negative value is negated, and 0x80000000 saturates to 0x7FFFFFFF. The result never has its top bit set.
- R4: After an accepted operation, the zero flag is 1 exactly when the result of that operation was all zeros.
- R5: After an accepted operation, the negative flag equals the top bit of the result of that operation.
- R6: The carry flag is cleared by every accepted operation. The overflow flag is cleared by code 2'b00 and 2'b01 even when the operand difference would wrap, and code 2'b10 sets it only for input 0x80000000.
- R7: Flags load only on a rising clock edge with valid high and a non-reserved code. With valid low they hold their values.
- R8: The sticky overflow flag is the OR of its previous value with each new overflow, and it stays set through later operations that do not overflow.
- R9: A high clear input empties the sticky flag on the next edge. An overflow accepted on that same edge still sets it. The clear leaves the other flags untouched.
- R10: Operation code 2'b11 is reserved. It produces an all-zero result and leaves every flag unchanged, even when valid is high.
- R11: An active-low reset clears all five flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| valid_i | input | 1 | Operation accepted on this edge |
| op_i | input | 2 | 00 max, 01 min, 10 magnitude of A, 11 reserved |
| opa_i | input | 32 | Operand A (signed) |
| opb_i | input | 32 | Operand B (signed), ignored by magnitude |
| sticky_clr_i | input | 1 | Empties the sticky overflow flag |
| result_o | output | 32 | Combinational result |
| zero_o | output | 1 | Last accepted result was zero |
| neg_o | output | 1 | Top bit of last accepted result |
| carry_o | output | 1 | Carry flag, cleared by accepted operations |
| ovf_o | output | 1 | Overflow of the last accepted operation |
| ovf_sticky_o | output | 1 | Accumulated overflow |

## Verification
Only one input value makes the overflow flags move, so the sticky behaviour is hard to reach from the ports. The stimulus drives the magnitude of 0x80000000 and then follows it with non-overflowing operations, a reserved code and an idle cycle, and checks that the sticky and overflow bits behave differently. It then asserts the clear alone, and after that asserts the clear on the same edge as another saturating magnitude, to cover the priority between emptying and setting. Wrap-prone comparisons such as max of 0x800FFFFF and 0x7FFFFFFF confirm that no overflow leaks out of the compare path.

// File: rtl/sminmax_abs.sv
module sminmax_abs #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             sticky_clr_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             ovf_sticky_o
);
  localparam logic [1:0] OP_MAX = 2'b00;
  localparam logic [1:0] OP_MIN = 2'b01;
  localparam logic [1:0] OP_ABS = 2'b10;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] MOST_POS = ~MOST_NEG;

  logic             a_gt_b;
  logic             a_is_min;
  logic [WIDTH-1:0] a_negated;
  logic             ovf_now;
  logic             take;

  assign a_gt_b    = $signed(opa_i) > $signed(opb_i);
  assign a_is_min  = (opa_i == MOST_NEG);
  assign a_negated = '0 - opa_i;
  assign take      = valid_i && (op_i != 2'b11);

  always_comb begin
    result_o = '0;
    ovf_now  = 1'b0;
    case (op_i)
      OP_MAX: result_o = a_gt_b ? opa_i : opb_i;
      OP_MIN: result_o = a_gt_b ? opb_i : opa_i;
      OP_ABS: begin
        if (a_is_min) begin
          result_o = MOST_POS;
          ovf_now  = 1'b1;
        end else begin
          result_o = opa_i[WIDTH-1] ? a_negated : opa_i;
        end
      end
      default: result_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_o       <= 1'b0;
      neg_o        <= 1'b0;
      carry_o      <= 1'b0;
      ovf_o        <= 1'b0;
      ovf_sticky_o <= 1'b0;
    end else begin
      if (take) begin
        zero_o  <= (result_o == '0);
        neg_o   <= result_o[WIDTH-1];
        carry_o <= 1'b0;
        ovf_o   <= ovf_now;
      end
      ovf_sticky_o <= (ovf_sticky_o & ~sticky_clr_i) | (take & ovf_now);
    end
  end
endmodule

module sminmax_abs_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] opa_i,
  input logic             sticky_clr_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             neg_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             ovf_sticky_o
);
  assert_abs_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b10) |-> !result_o[WIDTH-1]);

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != 2'b11) |=> (zero_o == ($past(result_o) == '0)));

  assert_neg_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != 2'b11) |=> (neg_o == $past(result_o[WIDTH-1])));

  assert_cmp_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !op_i[1]) |=> (!ovf_o && !carry_o));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable({zero_o, neg_o, carry_o, ovf_o}));

  assert_sticky_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky_o && !sticky_clr_i) |=> ovf_sticky_o);

  assert_sticky_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr_i && !valid_i) |=> !ovf_sticky_o);

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b11) |-> (result_o == '0));

  assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b11) |=> $stable({zero_o, neg_o, carry_o, ovf_o}));
endmodule

bind sminmax_abs sminmax_abs_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .opa_i(opa_i),
  .sticky_clr_i(sticky_clr_i), .result_o(result_o), .zero_o(zero_o),
  .neg_o(neg_o), .carry_o(carry_o), .ovf_o(ovf_o), .ovf_sticky_o(ovf_sticky_o)
);

// File: tb/sminmax_abs_tb.sv
module sminmax_abs_tb;
  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic        z;
    logic        n;
    logic        v;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 32'h00000001, 32'h00000000, 32'h00000001, 1'b0, 1'b0, 1'b0},
    '{2'd0, 32'h00000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 1'b0},
    '{2'd0, 32'h7fffffff, 32'hffffffff, 32'h7fffffff, 1'b0, 1'b0, 1'b0},
    '{2'd0, 32'hffffffff, 32'h7fffffff, 32'h7fffffff, 1'b0, 1'b0, 1'b0},
    '{2'd0, 32'h800fffff, 32'h7fffffff, 32'h7fffffff, 1'b0, 1'b0, 1'b0},
    '{2'd0, 32'h80000080, 32'h80000080, 32'h80000080, 1'b0, 1'b1, 1'b0},
    '{2'd1, 32'h00000001, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 1'b0},
    '{2'd1, 32'h80000001, 32'h00000000, 32'h80000001, 1'b0, 1'b1, 1'b0},
    '{2'd1, 32'h80000001, 32'h0ff00000, 32'h80000001, 1'b0, 1'b1, 1'b0},
    '{2'd1, 32'h80000001, 32'h80000001, 32'h80000001, 1'b0, 1'b1, 1'b0},
    '{2'd2, 32'h80000001, 32'h12345678, 32'h7fffffff, 1'b0, 1'b0, 1'b0},
    '{2'd2, 32'h00000001, 32'hdeadbeef, 32'h00000001, 1'b0, 1'b0, 1'b0},
    '{2'd2, 32'h80000000, 32'h00000000, 32'h7fffffff, 1'b0, 1'b0, 1'b1},
    '{2'd2, 32'hffffffff, 32'h00000000, 32'h00000001, 1'b0, 1'b0, 1'b0},
    '{2'd2, 32'h00000000, 32'hffffffff, 32'h00000000, 1'b1, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        sticky_clr_i = 1'b0;
  logic [31:0] result_o;
  logic        zero_o, neg_o, carry_o, ovf_o, ovf_sticky_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic exp_s = 1'b0;

  always #2 clk = ~clk;

  sminmax_abs u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .sticky_clr_i(sticky_clr_i),
    .result_o(result_o), .zero_o(zero_o), .neg_o(neg_o), .carry_o(carry_o),
    .ovf_o(ovf_o), .ovf_sticky_o(ovf_sticky_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic flags(input string req, input logic z, input logic n, input logic v, input logic s);
    chk({req, " zero"}, {31'd0, zero_o}, {31'd0, z});
    chk({req, " neg"}, {31'd0, neg_o}, {31'd0, n});
    chk({req, " carry"}, {31'd0, carry_o}, 32'd0);
    chk({req, " ovf"}, {31'd0, ovf_o}, {31'd0, v});
    chk({req, " sticky"}, {31'd0, ovf_sticky_o}, {31'd0, s});
  endtask

  task automatic drive(input logic vld, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic clr);
    @(negedge clk);
    valid_i = vld; op_i = op; opa_i = a; opb_i = b; sticky_clr_i = clr;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    valid_i = 1'b0; sticky_clr_i = 1'b0; op_i = 2'b00;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    flags("R11 reset", 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = (VECS[i].op == 2'd0) ? "R1" : (VECS[i].op == 2'd1) ? "R2" : "R3";
      drive(1'b1, VECS[i].op, VECS[i].a, VECS[i].b, 1'b0);
      chk(tag, result_o, VECS[i].r);
      settle();
      exp_s = exp_s | VECS[i].v;
      chk("R4 zero", {31'd0, zero_o}, {31'd0, VECS[i].z});
      chk("R5 neg", {31'd0, neg_o}, {31'd0, VECS[i].n});
      chk("R6 carry", {31'd0, carry_o}, 32'd0);
      chk("R6 ovf", {31'd0, ovf_o}, {31'd0, VECS[i].v});
      chk("R8 sticky", {31'd0, ovf_sticky_o}, {31'd0, exp_s});
    end

    drive(1'b1, 2'd2, 32'h80000000, 32'h0, 1'b0);
    settle();
    flags("R3 saturate", 1'b0, 1'b0, 1'b1, 1'b1);

    drive(1'b1, 2'd3, 32'h80000000, 32'h00000005, 1'b0);
    chk("R10 result", result_o, 32'h0);
    settle();
    flags("R10 hold", 1'b0, 1'b0, 1'b1, 1'b1);

    drive(1'b0, 2'd1, 32'h0, 32'h0, 1'b0);
    chk("R2 idle result", result_o, 32'h0);
    settle();
    flags("R7 idle", 1'b0, 1'b0, 1'b1, 1'b1);

    drive(1'b0, 2'd0, 32'h0, 32'h0, 1'b1);
    settle();
    flags("R9 clear", 1'b0, 1'b0, 1'b1, 1'b0);

    drive(1'b1, 2'd2, 32'h80000000, 32'h0, 1'b1);
    settle();
    flags("R9 clear with ovf", 1'b0, 1'b0, 1'b1, 1'b1);

    drive(1'b1, 2'd0, 32'h80000000, 32'h80000000, 1'b0);
    settle();
    flags("R8 cmp keeps sticky", 1'b0, 1'b1, 1'b0, 1'b1);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    flags("R11 mid reset", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule